// File: doc/BRIEF.md
# Parallel Printer Port Register Block with Local Printer Emulation

This block is the host side of a byte-wide parallel printer port. A CPU reaches it through a small register bus with a 3-bit address, separate read and write strobes and 8-bit data. Three registers are decoded: a data latch, a status register and a control register. The control register drives the printer-side control lines as active-low pins. The data latch drives the printer data bus, unless the control register turns the port around to input.

There is no real printer behind the port. The block imitates one in a fixed sequence:
- Pulling the init control bit low loads a fixed "idle printer" status pattern.
- Raising the strobe bit while select is set hands the latched byte to a transmit output and marks the printer busy.
- Each later status read moves the acknowledge/busy handshake forward by exactly one step, with no real-time delay.

A sent byte leaves an interrupt pending. The interrupt line shows that pending flag, gated by the interrupt-enable control bit.

Top module: `lpt_host_regs`

## Requirements
- R1: After reset, the status register reads 0xD9, the control register reads 0xCC and irq is low. The pins also take reset levels: lpt_strobe_n=1, lpt_autofd_n=1, lpt_init_n=1, lpt_selin_n=0.
- R2: Register offsets are fixed:
  - offset 0 is data, offset 1 is status and offset 2 is control;
  - reads of offsets 3 to 7 return 0xFF;
  - writes to offsets 3 to 7 change nothing.
- R3: The control register holds six bits:
  - bit 5 is direction (1 = input);
  - bit 4 is interrupt enable;
  - bit 3 is select-in;
  - bit 2 is init (active when 0);
  - bit 1 is autofeed;
  - bit 0 is strobe.

  A control read returns bits 7:6 as 1 above the stored bits. The pins are lpt_strobe_n = !bit0, lpt_autofd_n = !bit1, lpt_init_n = bit2 and lpt_selin_n = !bit3.
- R4: lpt_data_out always carries the last byte written to offset 0. lpt_data_oe = !control bit 5. A data read returns lpt_data_in when control bit 5 is 1, and the latched byte when it is 0.
- R5: A control write with bit 2 = 0 loads status with 0xD8: ready (bit 7), ack (bit 6), online (bit 4) and no-error (bit 3) all set, and the timeout flag (bit 0) cleared.
- R6: A control write with bit 2 = 1, bit 3 = 1 and bit 0 = 1 clears status bit 7. If the stored control bit 0 was 0 before that write, the write also does two things:
  - tx_valid goes high for exactly the next cycle, with tx_byte equal to the data latch;
  - an interrupt becomes pending.
- R7: A status read handshake runs only when status bit 7 is 0 and control bit 0 is 0. In that case:
  - if status bit 6 is 1, the read clears bit 6;
  - otherwise the read sets both bit 6 and bit 7.

  In every other state a status read leaves the status unchanged.
- R8: irq equals control bit 4 AND the pending flag. Every status read clears the pending flag.
- R9: A status write with bit 0 = 1 clears the timeout flag (status bit 0). No other status bit is ever changed by a status write.
- R10: rdata shows the read value from the cycle after the read strobe, and holds it until the next read. A status read returns the value from before that read's own handshake step.
- R11: Status bit 5 as read always equals the lpt_paper_in pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request |
| lpt_data_out | output | 8 | Printer data bus, output value |
| lpt_data_oe | output | 1 | Data bus output enable |
| lpt_data_in | input | 8 | Printer data bus, input value |
| lpt_strobe_n | output | 1 | Strobe pin, active low |
| lpt_autofd_n | output | 1 | Autofeed pin, active low |
| lpt_init_n | output | 1 | Init pin, active low |
| lpt_selin_n | output | 1 | Select-in pin, active low |
| lpt_paper_in | input | 1 | Paper-out status pin |
| tx_valid | output | 1 | One-cycle pulse: byte handed to the emulated printer |
| tx_byte | output | 8 | Byte handed over with tx_valid |

## Verification
The hardest state to reach is the second half of the handshake. Getting there needs three things in order:
1. a strobe write under select, which clears ready;
2. a separate control write that drops the strobe bit;
3. two status reads: the first clears ack and the second restores ready.

The bench walks that exact sequence, with reads placed between the steps, so that a read taken while strobe is still high is seen to do nothing. It also repeats a strobe write without an edge to prove no second byte goes out. Finally, it sends a byte with interrupts disabled and then enables them, so that irq rises from the enable alone.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
   localparam int BYTE_W = 8;
   localparam int CTRL_W = 6;

   localparam int ST_READY  = 7;
   localparam int ST_ACK    = 6;
   localparam int ST_PAPER  = 5;
   localparam int ST_ONLINE = 4;
   localparam int ST_NOERR  = 3;
   localparam int ST_TMO    = 0;

   localparam int CT_DIR   = 5;
   localparam int CT_IE    = 4;
   localparam int CT_SEL   = 3;
   localparam int CT_INITN = 2;
   localparam int CT_AFD   = 1;
   localparam int CT_STB   = 0;

   localparam logic [BYTE_W-1:0] STAT_RESET = 8'hD9;
   localparam logic [BYTE_W-1:0] STAT_IDLE  = 8'hD8;
   localparam logic [CTRL_W-1:0] CTRL_RESET = 6'h0C;
   localparam logic [BYTE_W-CTRL_W-1:0] CTRL_PAD = '1;
endpackage

// File: rtl/lpt_ctrl_reg.sv
module lpt_ctrl_reg
   import lpt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic              wr_data,
   input  logic [BYTE_W-1:0] wdata,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic [BYTE_W-1:0] data_q,
   output logic              launch,
   output logic              tx_valid,
   output logic [BYTE_W-1:0] tx_byte
);
   logic strobe_cmd;

   assign strobe_cmd = wdata[CT_INITN] & wdata[CT_SEL] & wdata[CT_STB];
   assign launch     = wr_ctrl & strobe_cmd & ~ctrl_q[CT_STB];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= CTRL_RESET;
         data_q   <= '0;
         tx_valid <= 1'b0;
         tx_byte  <= '0;
      end else begin
         tx_valid <= launch;
         if (launch) tx_byte <= data_q;
         if (wr_ctrl) ctrl_q <= wdata[CTRL_W-1:0];
         if (wr_data) data_q <= wdata;
      end
   end

   assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |=> !tx_valid);
endmodule

// File: rtl/lpt_status_emu.sv
module lpt_status_emu
   import lpt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic              wr_stat,
   input  logic              rd_stat,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              stb_q,
   input  logic              launch,
   output logic [BYTE_W-1:0] stat_q,
   output logic              pend_q
);
   logic [BYTE_W-1:0] stat_d;
   logic              pend_d;

   always_comb begin
      stat_d = stat_q;
      pend_d = pend_q;
      if (wr_ctrl) begin
         if (!wdata[CT_INITN])
            stat_d = STAT_IDLE;
         else if (wdata[CT_SEL] && wdata[CT_STB])
            stat_d[ST_READY] = 1'b0;
         if (launch) pend_d = 1'b1;
      end else if (wr_stat) begin
         if (wdata[ST_TMO]) stat_d[ST_TMO] = 1'b0;
      end else if (rd_stat) begin
         pend_d = 1'b0;
         if (!stat_q[ST_READY] && !stb_q) begin
            if (stat_q[ST_ACK]) begin
               stat_d[ST_ACK] = 1'b0;
            end else begin
               stat_d[ST_ACK]   = 1'b1;
               stat_d[ST_READY] = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q <= STAT_RESET;
         pend_q <= 1'b0;
      end else begin
         stat_q <= stat_d;
         pend_q <= pend_d;
      end
   end

   assert_init_pattern_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !wdata[CT_INITN]) |=> (stat_q == STAT_IDLE));
   assert_launch_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> !stat_q[ST_READY] && pend_q);
   assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stat |=> !pend_q);
endmodule

// File: rtl/lpt_rd_mux.sv
module lpt_rd_mux
   import lpt_pkg::*;
#(
   parameter int          ADDR_W    = 3,
   parameter int          OFS_DATA  = 0,
   parameter int          OFS_STAT  = 1,
   parameter int          OFS_CTRL  = 2,
   parameter logic [7:0]  IDLE_READ = 8'hFF,
   parameter bit          RD_REG    = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] data_q,
   input  logic [BYTE_W-1:0] pins_in,
   input  logic [CTRL_W-1:0] ctrl_q,
   input  logic [BYTE_W-1:0] stat_q,
   input  logic              paper_in,
   output logic [BYTE_W-1:0] rdata
);
   logic [BYTE_W-1:0] sel_val;
   logic [BYTE_W-1:0] stat_view;

   always_comb begin
      stat_view           = stat_q;
      stat_view[ST_PAPER] = paper_in;
      if (addr == ADDR_W'(OFS_DATA))
         sel_val = ctrl_q[CT_DIR] ? pins_in : data_q;
      else if (addr == ADDR_W'(OFS_STAT))
         sel_val = stat_view;
      else if (addr == ADDR_W'(OFS_CTRL))
         sel_val = {CTRL_PAD, ctrl_q};
      else
         sel_val = IDLE_READ;
   end

   generate
      if (RD_REG) begin : g_reg
         logic [BYTE_W-1:0] hold_q;
         always_ff @(posedge clk) begin
            if (!rst_n)  hold_q <= '0;
            else if (rd) hold_q <= sel_val;
         end
         assign rdata = hold_q;
      end else begin : g_comb
         assign rdata = rd ? sel_val : '0;
      end
   endgenerate
endmodule

// File: rtl/lpt_host_regs.sv
module lpt_host_regs
   import lpt_pkg::*;
#(
   parameter int         ADDR_W    = 3,
   parameter int         OFS_DATA  = 0,
   parameter int         OFS_STAT  = 1,
   parameter int         OFS_CTRL  = 2,
   parameter logic [7:0] IDLE_READ = 8'hFF,
   parameter bit         RD_REG    = 1'b1
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic [2:0]  bus_addr,
   input  logic        bus_wr,
   input  logic        bus_rd,
   input  logic [7:0]  bus_wdata,
   output logic [7:0]  bus_rdata,
   output logic        irq,
   output logic [7:0]  lpt_data_out,
   output logic        lpt_data_oe,
   input  logic [7:0]  lpt_data_in,
   output logic        lpt_strobe_n,
   output logic        lpt_autofd_n,
   output logic        lpt_init_n,
   output logic        lpt_selin_n,
   input  logic        lpt_paper_in,
   output logic        tx_valid,
   output logic [7:0]  tx_byte
);
   localparam int NUM_OFS = 1 << ADDR_W;

   generate
      if (ADDR_W != 3) begin : g_bad_aw
         $error("lpt_host_regs: ADDR_W must equal the bus address width 3");
      end
      if (OFS_DATA >= NUM_OFS || OFS_STAT >= NUM_OFS || OFS_CTRL >= NUM_OFS) begin : g_bad_range
         $error("lpt_host_regs: register offset outside address space");
      end
      if (OFS_DATA == OFS_STAT || OFS_DATA == OFS_CTRL || OFS_STAT == OFS_CTRL) begin : g_bad_overlap
         $error("lpt_host_regs: register offsets overlap");
      end
   endgenerate

   logic              wr_data, wr_stat, wr_ctrl, rd_stat;
   logic [CTRL_W-1:0] ctrl_q;
   logic [BYTE_W-1:0] data_q, stat_q;
   logic              launch, pend_q;

   assign wr_data = bus_wr && (bus_addr == ADDR_W'(OFS_DATA));
   assign wr_stat = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
   assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
   assign rd_stat = bus_rd && !bus_wr && (bus_addr == ADDR_W'(OFS_STAT));

   lpt_ctrl_reg u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ctrl  (wr_ctrl),
      .wr_data  (wr_data),
      .wdata    (bus_wdata),
      .ctrl_q   (ctrl_q),
      .data_q   (data_q),
      .launch   (launch),
      .tx_valid (tx_valid),
      .tx_byte  (tx_byte)
   );

   lpt_status_emu u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctrl (wr_ctrl),
      .wr_stat (wr_stat),
      .rd_stat (rd_stat),
      .wdata   (bus_wdata),
      .stb_q   (ctrl_q[CT_STB]),
      .launch  (launch),
      .stat_q  (stat_q),
      .pend_q  (pend_q)
   );

   lpt_rd_mux #(
      .ADDR_W    (ADDR_W),
      .OFS_DATA  (OFS_DATA),
      .OFS_STAT  (OFS_STAT),
      .OFS_CTRL  (OFS_CTRL),
      .IDLE_READ (IDLE_READ),
      .RD_REG    (RD_REG)
   ) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd       (bus_rd && !bus_wr),
      .addr     (bus_addr),
      .data_q   (data_q),
      .pins_in  (lpt_data_in),
      .ctrl_q   (ctrl_q),
      .stat_q   (stat_q),
      .paper_in (lpt_paper_in),
      .rdata    (bus_rdata)
   );

   assign irq          = ctrl_q[CT_IE] & pend_q;
   assign lpt_data_out = data_q;
   assign lpt_data_oe  = ~ctrl_q[CT_DIR];
   assign lpt_strobe_n = ~ctrl_q[CT_STB];
   assign lpt_autofd_n = ~ctrl_q[CT_AFD];
   assign lpt_init_n   =  ctrl_q[CT_INITN];
   assign lpt_selin_n  = ~ctrl_q[CT_SEL];

   assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(bus_wr && bus_addr == ADDR_W'(OFS_CTRL)));
   assert_tx_matches_pins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> (tx_byte == lpt_data_out) && !lpt_strobe_n && !lpt_selin_n);
endmodule

// File: tb/sim_lpt_host_regs.sv
module sim_lpt_host_regs;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] bus_addr = '0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       irq;
   logic [7:0] lpt_data_out;
   logic       lpt_data_oe;
   logic [7:0] lpt_data_in = '0;
   logic       lpt_strobe_n, lpt_autofd_n, lpt_init_n, lpt_selin_n;
   logic       lpt_paper_in = 1'b0;
   logic       tx_valid;
   logic [7:0] tx_byte;

   int n_chk = 0, n_fail = 0, cyc = 0;

   always #10 clk = ~clk;

   lpt_host_regs u0 (.*);

   // behavioural reference state
   logic [7:0] m_data, m_stat, m_rdata, m_txb;
   logic [5:0] m_ctrl;
   logic       m_pend, m_tx;

   function automatic logic [7:0] m_view(input logic [2:0] a);
      case (a)
         3'd0: return m_ctrl[5] ? lpt_data_in : m_data;
         3'd1: return (m_stat & 8'hDF) | (lpt_paper_in ? 8'h20 : 8'h00);
         3'd2: return {2'b11, m_ctrl};
         default: return 8'hFF;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_data = 0; m_stat = 8'hD9; m_ctrl = 6'h0C; m_pend = 0;
         m_rdata = 0; m_tx = 0; m_txb = 0;
      end else begin
         m_tx = 0;
         if (bus_rd && !bus_wr) begin
            m_rdata = m_view(bus_addr);
            if (bus_addr == 3'd1) begin
               m_pend = 0;
               if (!m_stat[7] && !m_ctrl[0]) begin
                  if (m_stat[6]) m_stat[6] = 0;
                  else m_stat = m_stat | 8'hC0;
               end
            end
         end
         if (bus_wr) begin
            case (bus_addr)
               3'd0: m_data = bus_wdata;
               3'd1: if (bus_wdata[0]) m_stat[0] = 0;
               3'd2: begin
                  if (!bus_wdata[2]) m_stat = 8'hD8;
                  else if (bus_wdata[3] && bus_wdata[0]) begin
                     m_stat[7] = 0;
                     if (!m_ctrl[0]) begin m_tx = 1; m_txb = m_data; m_pend = 1; end
                  end
                  m_ctrl = bus_wdata[5:0];
               end
               default: ;
            endcase
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // compare against the model every cycle
   always @(negedge clk) begin
      if (rst_n) begin
         chk(lpt_data_out == m_data, "R4 data_out", lpt_data_out, m_data);
         chk(lpt_data_oe == !m_ctrl[5], "R4 data_oe", lpt_data_oe, !m_ctrl[5]);
         chk({lpt_selin_n, lpt_init_n, lpt_autofd_n, lpt_strobe_n} ==
             {!m_ctrl[3], m_ctrl[2], !m_ctrl[1], !m_ctrl[0]}, "R3 pins",
             {lpt_selin_n, lpt_init_n, lpt_autofd_n, lpt_strobe_n},
             {!m_ctrl[3], m_ctrl[2], !m_ctrl[1], !m_ctrl[0]});
         chk(irq == (m_ctrl[4] && m_pend), "R8 irq", irq, m_ctrl[4] && m_pend);
         chk(tx_valid == m_tx, "R6 tx_valid", tx_valid, m_tx);
         if (m_tx) chk(tx_byte == m_txb, "R6 tx_byte", tx_byte, m_txb);
         chk(bus_rdata == m_rdata, "R10 rdata", bus_rdata, m_rdata);
      end
   end

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
      @(negedge clk); bus_wr = 0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk); bus_addr = a; bus_rd = 1;
      @(negedge clk); bus_rd = 0;
      chk(bus_rdata == exp, tag, bus_rdata, exp);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(irq == 0, "R1 irq", irq, 0);
      chk({lpt_strobe_n, lpt_autofd_n, lpt_init_n, lpt_selin_n} == 4'b1110, "R1 pins",
          {lpt_strobe_n, lpt_autofd_n, lpt_init_n, lpt_selin_n}, 4'b1110);
      rd(3'd1, 8'hD9, "R1 status");
      rd(3'd2, 8'hCC, "R1 control");
      // R2 unused offsets
      rd(3'd5, 8'hFF, "R2 unused read");
      // R4 data path and direction
      wr(3'd0, 8'hA5);
      rd(3'd0, 8'hA5, "R4 data latch");
      lpt_data_in = 8'h3C;
      wr(3'd2, 8'h2C);
      rd(3'd0, 8'h3C, "R4 data input");
      chk(lpt_data_oe == 0, "R4 oe off", lpt_data_oe, 0);
      wr(3'd2, 8'h0C);
      wr(3'd7, 8'h00);
      rd(3'd0, 8'hA5, "R2 write ignored data");
      rd(3'd2, 8'hCC, "R2 write ignored ctrl");
      // R3 pin mapping
      wr(3'd2, 8'h0E);
      chk(lpt_autofd_n == 0, "R3 autofd", lpt_autofd_n, 0);
      // R6 strobe with interrupt enabled
      wr(3'd2, 8'h1C);
      wr(3'd2, 8'h1D);
      chk(tx_valid == 1 && tx_byte == 8'hA5, "R6 tx", tx_byte, 8'hA5);
      chk(irq == 1, "R8 irq raised", irq, 1);
      // R7 handshake: strobe still high, no step
      rd(3'd1, 8'h59, "R7 busy read");
      chk(irq == 0, "R8 read clears", irq, 0);
      rd(3'd1, 8'h59, "R7 strobe high no step");
      wr(3'd2, 8'h1D);
      chk(tx_valid == 0, "R6 no edge no tx", tx_valid, 0);
      wr(3'd2, 8'h1C);
      rd(3'd1, 8'h59, "R7 pre ack clear");
      rd(3'd1, 8'h19, "R7 ack cleared");
      rd(3'd1, 8'hD9, "R7 ready restored");
      rd(3'd1, 8'hD9, "R7 idle no step");
      // R11 paper pin
      lpt_paper_in = 1;
      rd(3'd1, 8'hF9, "R11 paper");
      lpt_paper_in = 0;
      // R6 no select: no tx, ready kept
      wr(3'd2, 8'h04);
      wr(3'd2, 8'h05);
      chk(tx_valid == 0, "R6 no select", tx_valid, 0);
      rd(3'd1, 8'hD9, "R6 no select status");
      // R9 timeout clear via status write
      wr(3'd1, 8'hFE);
      rd(3'd1, 8'hD9, "R9 bit0 clear write ignored");
      wr(3'd1, 8'h01);
      rd(3'd1, 8'hD8, "R9 timeout cleared");
      // R8 send with irq disabled, then enable
      wr(3'd2, 8'h0C);
      wr(3'd0, 8'h5A);
      wr(3'd2, 8'h0D);
      chk(irq == 0, "R8 masked", irq, 0);
      wr(3'd2, 8'h1D);
      chk(irq == 1, "R8 enable raises", irq, 1);
      // R5 init forces idle pattern
      wr(3'd2, 8'h18);
      rd(3'd1, 8'hD8, "R5 init pattern");
      chk(lpt_init_n == 0, "R5 init pin", lpt_init_n, 0);
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule